// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by software into asynchronous serial frames on one output line. A register-style write port places bytes into a two-entry buffer. A one-cycle bit-rate tick, produced elsewhere, marks each bit period. On every tick the block either starts a new frame, shifts the next bit of the current frame, or leaves the line resting high.

A frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional odd or even parity bit, then one or two high stop bits. Software watches a space-available flag and a busy flag. It can refill the buffer from an interrupt or DMA channel, which is triggered by a one-cycle request pulse once the buffer has fully drained into the shifter. Dropping the enable input flushes everything that has not yet been sent. A write made while the buffer is full is lost and sets a sticky overflow flag.

Top module: `async_tx_buf`

## Requirements
- R1: The buffer holds up to DEPTH (default 2) bytes and sends them in write order, oldest first. Two writes in a row into an empty buffer are both accepted.
- R2: `spaceAvail` is 1 while at least one buffer entry is free, and it goes to 0 in the cycle after the write that fills the buffer.
- R3: A write made while a frame is being shifted out is accepted, and that byte is sent in a later frame.
- R4: `txBusy` goes to 1 on the tick that sends a start bit. It goes to 0 on the first tick after the last stop bit if the buffer is empty at that point.
- R5: On the first tick at which the buffer holds data and no frame is in progress, the oldest entry is removed and `serOut` is low (start bit) right after that clock edge.
- R6: Data bits follow the start bit one per tick, least significant bit first: 8 bits when `cfgSevenBit`=0, bits 6..0 when `cfgSevenBit`=1.
- R7: When `cfgParityEn`=1, one parity bit follows the last data bit. With `cfgParityOdd`=0 it is the XOR of the data bits sent; with `cfgParityOdd`=1 it is that XOR inverted.
- R8: Stop bits are high. There is one when `cfgTwoStop`=0 and two when it is 1.
- R9: If the buffer holds data when the last stop bit ends, the next tick sends the next start bit, with no idle bit time in between.
- R10: `emptyReq` is high for exactly one cycle, in the cycle right after a start that left the buffer empty, and at no other time.
- R11: While `txEnable`=0, the buffer is emptied, any frame in progress is abandoned, `serOut` is high, `txBusy` is 0, `overflow` is cleared and writes are ignored. Bytes flushed this way are never sent.
- R12: A write while the buffer is full is dropped and sets `overflow`, which then stays 1 until `txEnable` goes low.
- R13: Whenever `txBusy` is 0, `serOut` is high. After reset, `serOut`=1, `txBusy`=0, `spaceAvail`=1, `emptyReq`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnable | input | 1 | Transmit enable; low flushes the buffer and aborts any frame |
| wrValid | input | 1 | Write strobe for `wrData` |
| wrData | input | DATA_W | Byte to queue |
| bitTick | input | 1 | One-cycle pulse marking a bit period |
| cfgSevenBit | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfgParityEn | input | 1 | 1 adds a parity bit |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| serOut | output | 1 | Serial line, idle high |
| spaceAvail | output | 1 | Buffer has at least one free entry |
| txBusy | output | 1 | A frame is in progress |
| emptyReq | output | 1 | One-cycle interrupt/DMA request when the buffer drains |
| overflow | output | 1 | Sticky flag for a write lost while the buffer was full |

## Verification
The bench uses the default parameters, DATA_W=8 and DEPTH=2. With these values a third write overflows the buffer, and the 7-bit mode drops exactly the top bit of a byte. Every combination of data length, parity mode and stop-bit count is compared bit by bit against a frame model written into the bench. Ticks are spaced a few cycles apart, so a start bit, an emptying pulse and a back-to-back frame boundary each fall on a cycle that can be observed on its own.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef struct packed {
    logic flush;       // drop buffer and line to idle
    logic push;        // store wrData in buffer
    logic load;        // pop head into shifter, send start bit
    logic shiftData;   // send next data bit
    logic sendParity;  // send parity bit
    logic sendStop;    // send a stop bit
  } txStrobe_t;
endpackage

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      wrValid,
  input  logic      bitTick,
  input  logic      cfgSevenBit,
  input  logic      cfgParityEn,
  input  logic      cfgTwoStop,
  output txStrobe_t st,
  output logic      spaceAvail,
  output logic      txBusy,
  output logic      emptyReq,
  output logic      overflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int POS_W = $clog2(DATA_W + 5);

  logic [CNT_W-1:0] count;
  logic [POS_W-1:0] bitPos;
  logic             inFrame;
  logic [POS_W-1:0] dataBits;
  logic [POS_W-1:0] parBits;
  logic [POS_W-1:0] totalBits;
  logic             full;
  logic             lastBitDone;
  logic             runTick;

  assign full        = (count == CNT_W'(DEPTH));
  assign dataBits    = cfgSevenBit ? POS_W'(DATA_W - 1) : POS_W'(DATA_W);
  assign parBits     = cfgParityEn ? POS_W'(1) : POS_W'(0);
  assign totalBits   = POS_W'(1) + dataBits + parBits + (cfgTwoStop ? POS_W'(2) : POS_W'(1));
  assign runTick     = txEnable && bitTick;
  assign lastBitDone = inFrame && (bitPos == totalBits);

  always_comb begin
    st            = '0;
    st.flush      = !txEnable;
    st.push       = txEnable && wrValid && !full;
    st.load       = runTick && (count != '0) && (!inFrame || lastBitDone);
    if (runTick && inFrame && !lastBitDone) begin
      if (bitPos <= dataBits)
        st.shiftData = 1'b1;
      else if (cfgParityEn && bitPos == dataBits + POS_W'(1))
        st.sendParity = 1'b1;
      else
        st.sendStop = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      bitPos   <= '0;
      inFrame  <= 1'b0;
      emptyReq <= 1'b0;
      overflow <= 1'b0;
    end else if (!txEnable) begin
      count    <= '0;
      bitPos   <= '0;
      inFrame  <= 1'b0;
      emptyReq <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (st.push && !st.load)
        count <= count + CNT_W'(1);
      else if (st.load && !st.push)
        count <= count - CNT_W'(1);
      if (wrValid && full)
        overflow <= 1'b1;
      emptyReq <= st.load && !st.push && (count == CNT_W'(1));
      if (st.load) begin
        inFrame <= 1'b1;
        bitPos  <= POS_W'(1);
      end else if (bitTick && inFrame) begin
        if (lastBitDone) begin
          inFrame <= 1'b0;
          bitPos  <= '0;
        end else begin
          bitPos <= bitPos + POS_W'(1);
        end
      end
    end
  end

  assign spaceAvail = !full;
  assign txBusy     = inFrame;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)) else $error("buffer count above depth"); // R1
  AST_EMPTY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    emptyReq |=> !emptyReq) else $error("empty request longer than one cycle"); // R10
  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (count == '0) && !inFrame) else $error("disable did not flush"); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow && txEnable |=> overflow) else $error("overflow flag lost"); // R12
endmodule

// File: rtl/async_tx_dpath.sv
module async_tx_dpath
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         st,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgSevenBit,
  input  logic              cfgParityOdd,
  output logic              serOut
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DATA_W-1:0] FULL_MASK = '1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] headMasked;
  logic [DATA_W-1:0] shiftReg;
  logic              parityBit;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (st.push && wrPtr == PTR_W'(e))
        mem[e] <= wrData;
    end
  end

  assign headMasked = mem[rdPtr] & (cfgSevenBit ? (FULL_MASK >> 1) : FULL_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      shiftReg  <= '0;
      parityBit <= 1'b0;
      serOut    <= 1'b1;
    end else if (st.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      serOut <= 1'b1;
    end else begin
      if (st.push)
        wrPtr <= nextPtr(wrPtr);
      if (st.load) begin
        rdPtr     <= nextPtr(rdPtr);
        shiftReg  <= headMasked;
        parityBit <= (^headMasked) ^ cfgParityOdd;
        serOut    <= 1'b0;
      end else if (st.shiftData) begin
        serOut   <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (st.sendParity) begin
        serOut <= parityBit;
      end else if (st.sendStop) begin
        serOut <= 1'b1;
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    st.load |=> !serOut) else $error("start bit not low"); // R5
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    st.sendStop |=> serOut) else $error("stop bit not high"); // R8
endmodule

// File: rtl/async_tx_buf.sv
module async_tx_buf
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bitTick,
  input  logic              cfgSevenBit,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  output logic              serOut,
  output logic              spaceAvail,
  output logic              txBusy,
  output logic              emptyReq,
  output logic              overflow
);
  txStrobe_t st;

  async_tx_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .wrValid(wrValid),
    .bitTick(bitTick), .cfgSevenBit(cfgSevenBit), .cfgParityEn(cfgParityEn),
    .cfgTwoStop(cfgTwoStop), .st(st), .spaceAvail(spaceAvail),
    .txBusy(txBusy), .emptyReq(emptyReq), .overflow(overflow)
  );

  async_tx_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .cfgSevenBit(cfgSevenBit), .cfgParityOdd(cfgParityOdd), .serOut(serOut)
  );

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> serOut) else $error("line low while not busy"); // R13
endmodule

// File: tb/async_tx_buf_tb.sv
module async_tx_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       bitTick = 1'b0;
  logic       cfgSevenBit = 1'b0;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       cfgTwoStop = 1'b0;
  logic       serOut, spaceAvail, txBusy, emptyReq, overflow;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  tickEmpty;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_tx_buf #(.DATA_W(8), .DEPTH(2)) dut_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .wrValid(wrValid),
    .wrData(wrData), .bitTick(bitTick), .cfgSevenBit(cfgSevenBit),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgTwoStop(cfgTwoStop), .serOut(serOut), .spaceAvail(spaceAvail),
    .txBusy(txBusy), .emptyReq(emptyReq), .overflow(overflow)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrData  = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // one tick; outputs are sampled on the negedge after the tick edge
  task automatic doTick();
    @(negedge clk);
    bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
    tickEmpty = emptyReq;
    repeat (TICK_GAP) @(negedge clk);
  endtask

  // frame model: compare every bit; optionally inject a write at data bit 3
  task automatic checkFrame(input logic [7:0] d, input bit expEmpty, input bit idleAfter,
                            input bit inject, input logic [7:0] injData);
    int nData = cfgSevenBit ? 7 : 8;
    logic [7:0] m = cfgSevenBit ? (d & 8'h7F) : d;
    bit par = (^m) ^ cfgParityOdd;
    doTick();
    check("R5", "start bit", serOut, 0);
    check("R4", "busy at start", txBusy, 1);
    check("R10", "empty pulse at start", tickEmpty, expEmpty);
    for (int i = 0; i < nData; i++) begin
      if (inject && i == 3) begin
        writeByte(injData);
        check("R3", "write accepted mid-frame", spaceAvail, 1);
      end
      doTick();
      check("R6", $sformatf("data bit %0d", i), serOut, int'(m[i]));
      check("R10", "no pulse mid-frame", tickEmpty, 0);
    end
    if (cfgParityEn) begin
      doTick();
      check("R7", "parity bit", serOut, int'(par));
    end
    doTick();
    check("R8", "stop bit 1", serOut, 1);
    if (cfgTwoStop) begin
      doTick();
      check("R8", "stop bit 2", serOut, 1);
      check("R4", "busy in stop 2", txBusy, 1);
    end
    if (idleAfter) begin
      doTick();
      check("R4", "busy cleared after frame", txBusy, 0);
      check("R13", "idle line high", serOut, 1);
    end
  endtask

  task automatic testReset();
    check("R13", "reset serOut", serOut, 1);
    check("R13", "reset txBusy", txBusy, 0);
    check("R13", "reset spaceAvail", spaceAvail, 1);
    check("R13", "reset emptyReq", emptyReq, 0);
    check("R13", "reset overflow", overflow, 0);
  endtask

  task automatic testAllFormats();
    for (int c = 0; c < 8; c++) begin
      cfgSevenBit  = c[0];
      cfgParityEn  = c[1];
      cfgTwoStop   = c[2];
      cfgParityOdd = c[0] ^ c[2];
      writeByte(8'hA5 ^ 8'(c * 8'h37));
      checkFrame(8'hA5 ^ 8'(c * 8'h37), 1'b1, 1'b1, 1'b0, 8'h00);
    end
    cfgParityEn = 1'b1;
    for (int o = 0; o < 2; o++) begin
      cfgSevenBit = 1'b0; cfgTwoStop = 1'b0; cfgParityOdd = o[0];
      writeByte(8'h00);
      checkFrame(8'h00, 1'b1, 1'b1, 1'b0, 8'h00);  // R7 zero byte both parities
    end
  endtask

  task automatic testFullAndOrder();
    cfgSevenBit = 1'b0; cfgParityEn = 1'b1; cfgParityOdd = 1'b0; cfgTwoStop = 1'b1;
    writeByte(8'h3C);
    check("R2", "space after one write", spaceAvail, 1);
    writeByte(8'hC1);
    check("R1", "two writes accepted, full", spaceAvail, 0);
    check("R12", "no overflow yet", overflow, 0);
    writeByte(8'h77);
    check("R12", "overflow set", overflow, 1);
    check("R2", "still full", spaceAvail, 0);
    checkFrame(8'h3C, 1'b0, 1'b0, 1'b0, 8'h00);   // R1 oldest first
    check("R2", "space after first start", spaceAvail, 1);
    checkFrame(8'hC1, 1'b1, 1'b1, 1'b0, 8'h00);   // R9 no gap
    check("R12", "overflow sticky", overflow, 1);
    doTick();
    check("R12", "dropped byte never sent", txBusy, 0);
  endtask

  task automatic testMidFrameWrite();
    cfgSevenBit = 1'b1; cfgParityEn = 1'b0; cfgTwoStop = 1'b0;
    writeByte(8'h5A);
    checkFrame(8'h5A, 1'b1, 1'b0, 1'b1, 8'hE3);
    checkFrame(8'hE3, 1'b1, 1'b1, 1'b0, 8'h00);   // R3 R9
  endtask

  task automatic testDisable();
    cfgSevenBit = 1'b0; cfgParityEn = 1'b0; cfgTwoStop = 1'b0;
    writeByte(8'h81);
    writeByte(8'h42);
    writeByte(8'h99);
    doTick();
    check("R5", "start before disable", serOut, 0);
    doTick();
    @(negedge clk);
    txEnable = 1'b0;
    @(negedge clk);
    check("R11", "line high when disabled", serOut, 1);
    check("R11", "busy cleared", txBusy, 0);
    check("R11", "buffer flushed", spaceAvail, 1);
    check("R11", "overflow cleared", overflow, 0);
    writeByte(8'h0F);
    @(negedge clk);
    txEnable = 1'b1;
    @(negedge clk);
    check("R11", "write while disabled ignored", spaceAvail, 1);
    for (int k = 0; k < 4; k++) begin
      doTick();
      check("R11", "flushed bytes not sent", serOut, 1);
      check("R11", "stays idle", txBusy, 0);
      check("R10", "no pulse when empty", tickEmpty, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    txEnable = 1'b1;
    @(negedge clk);
    testAllFormats();
    testFullAndOrder();
    testMidFrameWrite();
    testDisable();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule